// File: doc/BRIEF.md
# Configurable GPIO Behaviour Controller

This block manages a bank of dual-use pins. Each pin either belongs to an alternate function or works as a general-purpose pin. A shared select register decides which. In general-purpose mode, a per-pin behaviour word sets several things:

- the direction of the pin;
- which level counts as "asserted";
- what an asserted input does.

An asserted input can keep a status bit that follows it or that latches. It can also raise requests for a cascade fault, an interrupt, alarm fan speed or hot-plug fan speed.

An output pin drives the OR of the fault events its second per-pin register selects, shaped by the same polarity bit. The alternate function and the sources of the events sit outside this block.

Software reaches the block through a flat write/read port with one byte per address. Incoming pins pass through a two-flop synchroniser before they are evaluated. All requests are active-high levels, and the chip edge turns the cascade fault request into its open-drain form.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads 0, every output enable is low, every pin output is low and all four request outputs are low.
- R2: Pin i is general-purpose only while bit i of the select register (address 0) is 1. While that bit is 0, the pin's output enable and output are low, and the pin raises no request.
- R3: Behaviour bit 0 set makes a selected pin an input and holds its output enable low. Bit 0 clear makes a selected pin an output with its output enable high.
- R4: Behaviour bit 1 picks polarity. With 1, an input is asserted when the synchronised level is high and an output drives its event OR directly. With 0, the input is asserted when low and the output drives the inverse of the event OR.
- R5: A pin level change reaches the requests after exactly two rising clock edges.
- R6: With behaviour bit 4 clear (follow mode), status bit 3 reads 1 one cycle after the input is asserted and 0 one cycle after it deasserts. Writes to bit 3 have no effect in this mode.
- R7: With behaviour bit 4 set (latch mode), status bit 3 becomes 1 when the input is asserted and stays 1 until software writes 1 to bit 3. While the input is still asserted, that clear loses to the set.
- R8: Behaviour bit 2 set makes the cascade fault request high while that input is asserted. The request is the OR over all pins.
- R9: Behaviour bits 5, 6 and 7 each make a request high while that input is asserted: bit 5 the interrupt request, bit 6 the alarm-speed request, bit 7 the hot-plug-speed request. Each request is the OR over all pins.
- R10: The event-select register of pin i (address 8+i) has six bits. From bit 0 up they are: temperature high, temperature low, fan fault, tach limit, analog high, analog low. They gate the matching bits of the event input. An output pin drives the OR of the gated events.
- R11: The register map is: select at address 0 (bits 0 to 5), behaviour of pin i at 1+i, event select of pin i at 8+i. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pin_i | input | 6 | Pin levels from the pads (asynchronous) |
| pin_o | output | 6 | Pin drive values |
| pin_oe_o | output | 6 | Pin output enables |
| evt_i | input | 6 | Fault event flags, one per event kind |
| cfault_req_o | output | 1 | Cascade fault request |
| int_req_o | output | 1 | Interrupt request |
| alarm_req_o | output | 1 | Alarm fan speed request |
| hotplug_req_o | output | 1 | Hot-plug fan speed request |

## Verification
Directed sequences cover several distinctions:

- Raising a single input line separates the two-edge synchroniser delay from a one-edge or three-edge path.
- Flipping the polarity under a fixed level separates active-high from active-low evaluation.
- A pulse followed by release separates follow from latch status.
- A write-one clear given while the input is still held checks the set priority.

Event patterns with one bit selected and another unselected show that only the gated events reach an output. Long random runs vary select, behaviour, event masks, pin levels and event flags all at once. These runs expose cross-pin OR mistakes and any wrong address decode.

// File: rtl/gpio_bank_pkg.sv
// Package: shared bit positions, event order and request bundle for the
// GPIO behaviour controller. Assumes 8-bit registers.
package gpio_bank_pkg;

    localparam int REG_W = 8;

    // Behaviour word bit positions
    localparam int B_IN    = 0;  // 1 = input
    localparam int B_POL   = 1;  // 1 = asserted high
    localparam int B_CF    = 2;  // cascade fault on assertion
    localparam int B_STAT  = 3;  // status (read) / clear (write 1, latch)
    localparam int B_LATCH = 4;  // 1 = sticky status
    localparam int B_INT   = 5;  // interrupt request
    localparam int B_ALARM = 6;  // alarm-speed request
    localparam int B_HOT   = 7;  // hot-plug-speed request

    // Event order in the event-select register and event input
    typedef enum int {
        EV_TEMP_HI = 0,
        EV_TEMP_LO = 1,
        EV_FAN     = 2,
        EV_TACH    = 3,
        EV_AIN_HI  = 4,
        EV_AIN_LO  = 5
    } evt_idx_e;

    typedef struct packed {
        logic cfault;
        logic irq;
        logic alarm;
        logic hotplug;
    } req_t;

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Purpose: two-stage capture of the pad levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/gpio_regmap.sv
// Module: register decode for the GPIO bank. Holds the pin-select register,
// produces per-pin write strobes and muxes read data.
// Assumes NPINS <= EVS_BASE - BEH_BASE so the two per-pin ranges never overlap.
module gpio_regmap #(
    parameter int NPINS    = 6,
    parameter int ADDR_W   = 4,
    parameter int EVT_W    = 6,
    parameter int SEL_ADDR = 0,
    parameter int BEH_BASE = 1,
    parameter int EVS_BASE = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic [ADDR_W-1:0]                          wr_addr,
    input  logic [gpio_bank_pkg::REG_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]                          rd_addr,
    input  logic [NPINS-1:0][gpio_bank_pkg::REG_W-1:0] beh_rd,
    input  logic [NPINS-1:0][EVT_W-1:0]                evs_rd,
    output logic [NPINS-1:0]                           sel_q,
    output logic [NPINS-1:0]                           beh_we,
    output logic [NPINS-1:0]                           evs_we,
    output logic [gpio_bank_pkg::REG_W-1:0]            rd_data
);
    import gpio_bank_pkg::*;

    localparam int PAD_SEL = REG_W - NPINS;
    localparam int PAD_EVS = REG_W - EVT_W;

    // Purpose: pin-select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(SEL_ADDR)) begin
            sel_q <= wr_data[NPINS-1:0];
        end
    end

    // Purpose: per-pin write strobes
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            beh_we[i] = wr_en && (wr_addr == ADDR_W'(BEH_BASE + i));
            evs_we[i] = wr_en && (wr_addr == ADDR_W'(EVS_BASE + i));
        end
    end

    // Purpose: read mux, zero for unmapped addresses
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(SEL_ADDR)) begin
            rd_data = {{PAD_SEL{1'b0}}, sel_q};
        end
        for (int i = 0; i < NPINS; i++) begin
            if (rd_addr == ADDR_W'(BEH_BASE + i)) begin
                rd_data = beh_rd[i];
            end
            if (rd_addr == ADDR_W'(EVS_BASE + i)) begin
                rd_data = {{PAD_EVS{1'b0}}, evs_rd[i]};
            end
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: behaviour logic for one pin. It holds the behaviour word and the
// event-select mask, evaluates the synchronised input, keeps the
// follow/latch status and drives the output from the selected events.
// Assumes pin_sync is already synchronised to clk.
module gpio_pin_ctrl #(
    parameter int EVT_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel,
    input  logic                            beh_we,
    input  logic                            evs_we,
    input  logic [gpio_bank_pkg::REG_W-1:0] wr_data,
    input  logic                            pin_sync,
    input  logic [EVT_W-1:0]                evt_i,
    output logic [gpio_bank_pkg::REG_W-1:0] beh_rd,
    output logic [EVT_W-1:0]                evs_rd,
    output logic                            drv_o,
    output logic                            oe_o,
    output gpio_bank_pkg::req_t             req_o,
    output logic                            asserted_o,
    output logic                            status_o,
    output logic                            latch_o,
    output logic                            in_mode_o,
    output logic                            pol_o,
    output logic                            clr_o,
    output logic                            hit_o
);
    import gpio_bank_pkg::*;

    logic [REG_W-1:0] cfg_q;
    logic [EVT_W-1:0] evs_q;
    logic             status_q;
    logic             status_d;
    logic             asserted;
    logic             clr;
    logic             hit;
    logic             drive_en;

    // Purpose: behaviour word storage (status slot is held separately)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (beh_we) begin
            cfg_q <= wr_data;
        end
    end

    // Purpose: event-select mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evs_q <= '0;
        end else if (evs_we) begin
            evs_q <= wr_data[EVT_W-1:0];
        end
    end

    // Purpose: input assertion after polarity, only for selected input pins
    always_comb begin
        asserted = sel && cfg_q[B_IN] && (cfg_q[B_POL] ? pin_sync : !pin_sync);
        clr      = beh_we && wr_data[B_STAT];
    end

    // Purpose: next status, follow or sticky with set over clear
    always_comb begin
        if (cfg_q[B_LATCH]) begin
            status_d = asserted || (status_q && !clr);
        end else begin
            status_d = asserted;
        end
    end

    // Purpose: status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= status_d;
        end
    end

    // Purpose: output drive from the OR of gated events
    always_comb begin
        hit      = |(evs_q & evt_i);
        drive_en = sel && !cfg_q[B_IN];
        oe_o     = drive_en;
        drv_o    = drive_en && (cfg_q[B_POL] ? hit : !hit);
    end

    // Purpose: per-pin action requests
    always_comb begin
        req_o.cfault  = asserted && cfg_q[B_CF];
        req_o.irq     = asserted && cfg_q[B_INT];
        req_o.alarm   = asserted && cfg_q[B_ALARM];
        req_o.hotplug = asserted && cfg_q[B_HOT];
    end

    assign beh_rd     = {cfg_q[REG_W-1:B_STAT+1], status_q, cfg_q[B_STAT-1:0]};
    assign evs_rd     = evs_q;
    assign asserted_o = asserted;
    assign status_o   = status_q;
    assign latch_o    = cfg_q[B_LATCH];
    assign in_mode_o  = cfg_q[B_IN];
    assign pol_o      = cfg_q[B_POL];
    assign clr_o      = clr;
    assign hit_o      = hit;

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the GPIO behaviour controller. It wires the synchroniser,
// the register map and one behaviour slice per pin, then ORs the per-pin
// requests. Assumes the event flags are synchronous to clk.
module gpio_bank_ctrl #(
    parameter int NPINS  = 6,
    parameter int ADDR_W = 4,
    parameter int EVT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              cfault_req_o,
    output logic              int_req_o,
    output logic              alarm_req_o,
    output logic              hotplug_req_o
);
    import gpio_bank_pkg::*;

    logic [NPINS-1:0]            pin_sync;
    logic [NPINS-1:0]            gpio_sel_q;
    logic [NPINS-1:0]            beh_we;
    logic [NPINS-1:0]            evs_we;
    logic [NPINS-1:0][REG_W-1:0] beh_rd;
    logic [NPINS-1:0][EVT_W-1:0] evs_rd;
    req_t [NPINS-1:0]            pin_req;
    logic [NPINS-1:0]            asserted;
    logic [NPINS-1:0]            status;
    logic [NPINS-1:0]            latch_mode;
    logic [NPINS-1:0]            in_mode;
    logic [NPINS-1:0]            polarity;
    logic [NPINS-1:0]            status_clr;
    logic [NPINS-1:0]            evt_hit;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (pin_sync)
    );

    gpio_regmap #(
        .NPINS  (NPINS),
        .ADDR_W (ADDR_W),
        .EVT_W  (EVT_W)
    ) u_regmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .beh_rd  (beh_rd),
        .evs_rd  (evs_rd),
        .sel_q   (gpio_sel_q),
        .beh_we  (beh_we),
        .evs_we  (evs_we),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_pin_ctrl #(.EVT_W(EVT_W)) u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (gpio_sel_q[g]),
            .beh_we     (beh_we[g]),
            .evs_we     (evs_we[g]),
            .wr_data    (wr_data),
            .pin_sync   (pin_sync[g]),
            .evt_i      (evt_i),
            .beh_rd     (beh_rd[g]),
            .evs_rd     (evs_rd[g]),
            .drv_o      (pin_o[g]),
            .oe_o       (pin_oe_o[g]),
            .req_o      (pin_req[g]),
            .asserted_o (asserted[g]),
            .status_o   (status[g]),
            .latch_o    (latch_mode[g]),
            .in_mode_o  (in_mode[g]),
            .pol_o      (polarity[g]),
            .clr_o      (status_clr[g]),
            .hit_o      (evt_hit[g])
        );
    end

    // Purpose: merge per-pin requests into the bank-wide request lines
    always_comb begin
        cfault_req_o  = 1'b0;
        int_req_o     = 1'b0;
        alarm_req_o   = 1'b0;
        hotplug_req_o = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            cfault_req_o  = cfault_req_o  | pin_req[i].cfault;
            int_req_o     = int_req_o     | pin_req[i].irq;
            alarm_req_o   = alarm_req_o   | pin_req[i].alarm;
            hotplug_req_o = hotplug_req_o | pin_req[i].hotplug;
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
// Module: assertion checker bound into gpio_bank_ctrl. It watches the
// status, gating and output-shaping rules per pin.
module gpio_bank_ctrl_chk #(
    parameter int NPINS = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] gpio_sel_q,
    input logic [NPINS-1:0] pin_o,
    input logic [NPINS-1:0] pin_oe_o,
    input logic [NPINS-1:0] asserted,
    input logic [NPINS-1:0] status,
    input logic [NPINS-1:0] latch_mode,
    input logic [NPINS-1:0] in_mode,
    input logic [NPINS-1:0] polarity,
    input logic [NPINS-1:0] status_clr,
    input logic [NPINS-1:0] evt_hit,
    input logic             cfault_req_o,
    input logic             int_req_o,
    input logic             alarm_req_o,
    input logic             hotplug_req_o
);

    // R2: no requests while every pin belongs to its alternate function
    a_r2_no_req_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_sel_q == '0) |-> !(cfault_req_o || int_req_o || alarm_req_o || hotplug_req_o));

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R3: an input pin never drives
        a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
            in_mode[g] |-> !pin_oe_o[g]);

        // R6: follow-mode status equals the previous cycle's assertion
        a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
            !latch_mode[g] |=> (status[g] == $past(asserted[g])));

        // R7: latched status holds without a clear
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_mode[g] && status[g] && !status_clr[g]) |=> status[g]);

        // R7: a clear with the input idle empties the status
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_mode[g] && status_clr[g] && !asserted[g]) |=> !status[g]);

        // R10: a driving pin with no gated event shows the idle level
        a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe_o[g] && !evt_hit[g]) |-> (pin_o[g] == !polarity[g]));
    end

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gpio_sel_q    (gpio_sel_q),
    .pin_o         (pin_o),
    .pin_oe_o      (pin_oe_o),
    .asserted      (asserted),
    .status        (status),
    .latch_mode    (latch_mode),
    .in_mode       (in_mode),
    .polarity      (polarity),
    .status_clr    (status_clr),
    .evt_hit       (evt_hit),
    .cfault_req_o  (cfault_req_o),
    .int_req_o     (int_req_o),
    .alarm_req_o   (alarm_req_o),
    .hotplug_req_o (hotplug_req_o)
);

// File: tb/sim_gpio_bank_ctrl.sv
// Bench: directed corner cases plus seeded random traffic, compared each
// cycle against a behavioural model built from the requirements.
module sim_gpio_bank_ctrl;

    localparam int N = 6;
    localparam int E = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [N-1:0] pin_i = '0;
    logic [N-1:0] pin_o;
    logic [N-1:0] pin_oe_o;
    logic [E-1:0] evt_i = '0;
    logic cfault_req_o, int_req_o, alarm_req_o, hotplug_req_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .evt_i(evt_i),
        .cfault_req_o(cfault_req_o), .int_req_o(int_req_o),
        .alarm_req_o(alarm_req_o), .hotplug_req_o(hotplug_req_o)
    );

    // Model state
    logic [N-1:0] m_sel;
    logic [7:0]   m_cfg [N];
    logic [E-1:0] m_evs [N];
    logic [N-1:0] m_s1, m_s2, m_stat;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic m_asrt(int i);
        return m_sel[i] && m_cfg[i][0] && (m_cfg[i][1] ? m_s2[i] : !m_s2[i]);
    endfunction

    function automatic logic m_oe(int i);
        return m_sel[i] && !m_cfg[i][0];
    endfunction

    function automatic logic m_drv(int i);
        logic hit;
        hit = |(m_evs[i] & evt_i);
        return m_oe(i) && (m_cfg[i][1] ? hit : !hit);
    endfunction

    function automatic logic m_req(int b);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N; i++) r = r | (m_asrt(i) && m_cfg[i][b]);
        return r;
    endfunction

    function automatic logic [7:0] m_rd(logic [3:0] a);
        logic [7:0] v;
        v = 8'h00;
        if (a == 4'd0) v = {2'b00, m_sel};
        for (int i = 0; i < N; i++) begin
            if (a == 4'(1 + i)) v = {m_cfg[i][7:4], m_stat[i], m_cfg[i][2:0]};
            if (a == 4'(8 + i)) v = {2'b00, m_evs[i]};
        end
        return v;
    endfunction

    task automatic model_reset();
        m_sel = '0; m_s1 = '0; m_s2 = '0; m_stat = '0;
        for (int i = 0; i < N; i++) begin
            m_cfg[i] = '0;
            m_evs[i] = '0;
        end
    endtask

    task automatic model_tick();
        logic [N-1:0] nstat;
        for (int i = 0; i < N; i++) begin
            logic clr;
            clr = wr_en && wr_addr == 4'(1 + i) && wr_data[3];
            nstat[i] = m_cfg[i][4] ? (m_asrt(i) || (m_stat[i] && !clr)) : m_asrt(i);
        end
        if (wr_en) begin
            if (wr_addr == 4'd0) m_sel = wr_data[N-1:0];
            for (int i = 0; i < N; i++) begin
                if (wr_addr == 4'(1 + i)) m_cfg[i] = wr_data & 8'hF7;
                if (wr_addr == 4'(8 + i)) m_evs[i] = wr_data[E-1:0];
            end
        end
        m_s2 = m_s1;
        m_s1 = pin_i;
        m_stat = nstat;
    endtask

    task automatic compare();
        chk("R3 oe", 32'(pin_oe_o), 32'({m_oe(5), m_oe(4), m_oe(3), m_oe(2), m_oe(1), m_oe(0)}));
        chk("R10 drive", 32'(pin_o), 32'({m_drv(5), m_drv(4), m_drv(3), m_drv(2), m_drv(1), m_drv(0)}));
        chk("R8 cfault", 32'(cfault_req_o), 32'(m_req(2)));
        chk("R9 int", 32'(int_req_o), 32'(m_req(5)));
        chk("R9 alarm", 32'(alarm_req_o), 32'(m_req(6)));
        chk("R9 hotplug", 32'(hotplug_req_o), 32'(m_req(7)));
        chk("R6 R7 R11 read", 32'(rd_data), 32'(m_rd(rd_addr)));
    endtask

    // One cycle: called at a falling edge with inputs already set
    task automatic step();
        #1;
        compare();
        model_tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 oe", 32'(pin_oe_o), 0);
        chk("R1 drive", 32'(pin_o), 0);
        chk("R1 req", 32'({cfault_req_o, int_req_o, alarm_req_o, hotplug_req_o}), 0);
        chk("R1 select", 32'(rd_data), 0);
        rst_n = 1'b1;

        // R11: select width and unmapped address
        wr(4'd0, 8'hFF);
        rd_addr = 4'd0; #1; chk("R11 select width", 32'(rd_data), 32'h3F);
        rd_addr = 4'd7; #1; chk("R11 unmapped", 32'(rd_data), 0);
        rd_addr = 4'd15; #1; chk("R11 unmapped", 32'(rd_data), 0);

        // R5, R8: active-high input with cascade fault
        wr(4'd1, 8'h07);
        idle(3);
        pin_i[0] = 1'b1;
        step();
        chk("R5 one edge", 32'(cfault_req_o), 0);
        step();
        chk("R5 two edges", 32'(cfault_req_o), 1);
        chk("R8 fault on", 32'(cfault_req_o), 1);
        wr(4'd1, 8'h03);
        chk("R8 fault off", 32'(cfault_req_o), 0);

        // R4: active-low evaluation
        wr(4'd1, 8'h05);
        chk("R4 high idle", 32'(cfault_req_o), 0);
        pin_i[0] = 1'b0;
        idle(2);
        chk("R4 low asserts", 32'(cfault_req_o), 1);

        // R2: deselect silences requests and drive
        wr(4'd2, 8'h00);
        chk("R2 oe on", 32'(pin_oe_o[1]), 1);
        wr(4'd0, 8'h00);
        chk("R2 req off", 32'(cfault_req_o), 0);
        chk("R2 oe off", 32'(pin_oe_o[1]), 0);
        wr(4'd0, 8'h3F);

        // R7: latch, hold, clear against held input, clear
        wr(4'd1, 8'h13);
        pin_i[0] = 1'b1; idle(3);
        rd_addr = 4'd1;
        wr(4'd1, 8'h1B);
        #1; chk("R7 set wins", 32'(rd_data[3]), 1);
        pin_i[0] = 1'b0; idle(3);
        #1; chk("R7 sticky", 32'(rd_data[3]), 1);
        wr(4'd1, 8'h1B);
        #1; chk("R7 cleared", 32'(rd_data[3]), 0);

        // R6: follow mode, write to status ignored
        wr(4'd1, 8'h03);
        pin_i[0] = 1'b1; idle(3);
        #1; chk("R6 follow set", 32'(rd_data[3]), 1);
        pin_i[0] = 1'b0; idle(3);
        wr(4'd1, 8'h0B);
        #1; chk("R6 follow clear", 32'(rd_data[3]), 0);

        // R9: interrupt, alarm, hot-plug
        wr(4'd1, 8'hE3);
        pin_i[0] = 1'b1; idle(3);
        chk("R9 int", 32'(int_req_o), 1);
        chk("R9 alarm", 32'(alarm_req_o), 1);
        chk("R9 hotplug", 32'(hotplug_req_o), 1);

        // R10, R3: output from gated events
        wr(4'd3, 8'h02);
        wr(4'd10, 8'h05);
        evt_i = 6'h04; #1;
        chk("R10 selected event", 32'(pin_o[2]), 1);
        evt_i = 6'h02; #1;
        chk("R10 unselected event", 32'(pin_o[2]), 0);
        wr(4'd3, 8'h00);
        chk("R10 inverted idle", 32'(pin_o[2]), 1);
        chk("R3 output oe", 32'(pin_oe_o[2]), 1);
        wr(4'd3, 8'h01);
        chk("R3 input oe", 32'(pin_oe_o[2]), 0);

        // Random traffic
        for (int k = 0; k < 6000; k++) begin
            wr_en   = ($urandom % 4) == 0;
            wr_addr = 4'($urandom);
            wr_data = 8'($urandom);
            rd_addr = 4'($urandom);
            evt_i   = 6'($urandom);
            if (($urandom % 3) == 0) pin_i = 6'($urandom);
            step();
        end
        wr_en = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule